// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address. It looks the address up in a two-level page table that sits in ordinary memory. The requester presents an address together with the current table base and table length. The walker first checks the outer index against the length bound. It then fetches one word from the outer table, follows that entry to an inner table, and fetches one word there. The result is a physical address built from the inner entry's frame bits and the untouched page offset. If the bound check fails, or an entry at either level is marked not present, the walker returns a fault code.

The address splits into three fields: a 12-bit outer index in bits 31:20, a 10-bit inner index in bits 19:10, and a 10-bit offset in bits 9:0 (1 KB pages). Table entries are 32-bit words. Bit 0 is the present flag, and bits 31:10 hold a 1 KB-aligned base. The memory port is a read request that stays up until a response strobe arrives, and the response may take any number of cycles. The walker takes one request at a time. It holds no cached translations, so every successful walk costs exactly two table reads.

Top module: `ptw_walker`

## Requirements
- R1: After reset, req_ready_o is 1, mem_req_o is 0 and rsp_valid_o is 0.
- R2: On success, rsp_paddr_o equals inner entry bits 31:10 concatenated with logical address bits 9:0, and rsp_code_o is 0.
- R3: The first table read goes to byte address ptbr_i + 4 × (logical bits 31:20), using the values sampled at acceptance.
- R4: The second table read goes to byte address {outer entry bits 31:10, ten zero bits} + 4 × (logical bits 19:10).
- R5: If the outer index is not below ptlr_i, the response has rsp_fault_o = 1 and rsp_code_o = 1, no memory read is issued, and the response comes the cycle after acceptance.
- R6: An outer entry with bit 0 = 0 gives rsp_fault_o = 1 and rsp_code_o = 2, after exactly one memory read.
- R7: An inner entry with bit 0 = 0 gives rsp_fault_o = 1 and rsp_code_o = 3, after exactly two memory reads.
- R8: Once raised, mem_req_o stays 1 and mem_addr_o stays unchanged until a cycle with mem_rvalid_i = 1, whatever the response delay.
- R9: A request is accepted only when req_ready_o = 1. While a walk is in progress req_ready_o is 0, and changes on req_vaddr_i, ptbr_i and ptlr_i do not affect the walk's reads or result.
- R10: rsp_valid_o is a one-cycle pulse, followed by req_ready_o = 1. Any faulting response drives rsp_paddr_o to 0.
- R11: A successful walk issues exactly two reads, outer table first and then inner table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request strobe |
| req_ready_o | output | 1 | Walker idle; a request is accepted this cycle |
| req_vaddr_i | input | 32 | Logical address to translate |
| ptbr_i | input | 32 | Byte address of the outer table |
| ptlr_i | input | 13 | Number of valid outer-table entries |
| mem_req_o | output | 1 | Table read request, held until answered |
| mem_addr_o | output | 32 | Byte address of the table word |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Table entry read back |
| rsp_valid_o | output | 1 | Result pulse |
| rsp_fault_o | output | 1 | Result is a fault |
| rsp_code_o | output | 2 | 0 ok, 1 length, 2 outer not present, 3 inner not present |
| rsp_paddr_o | output | 32 | Physical address on success, 0 on fault |

## Verification
The hardest situation to reach is a walk in which the requester's inputs change in the middle, while the memory is still stalling. Only then does a design that reads live inputs instead of latched ones give a different result. The bench therefore keeps req_valid_i high throughout every walk and scrambles the address, base and length on each busy cycle. It does this under response delays of zero to three cycles. The outer index is swept across the length boundary, and the present flag is forced off at each level in turn, so that every fault code appears with each latency.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_OUTER,
    ST_WT_OUTER,
    ST_RD_INNER,
    ST_WT_INNER,
    ST_DONE,
    ST_FAULT
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_LEN   = 2'd1,
    FLT_OUTER = 2'd2,
    FLT_INNER = 2'd3
  } fault_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 10,
  parameter int INNER_W = 10,
  parameter int WB      = 2
) (
  input  logic [ADDR_W-OFF_W-INNER_W-1:0] req_outer_i,
  input  logic [ADDR_W-OFF_W-INNER_W:0]   ptlr_i,
  input  logic [ADDR_W-1:0]               ptbr_q_i,
  input  logic [ADDR_W-OFF_W-INNER_W-1:0] outer_q_i,
  input  logic [INNER_W-1:0]              inner_q_i,
  input  logic [ADDR_W-OFF_W-1:0]         obase_q_i,
  output logic                            len_ok_o,
  output logic [ADDR_W-1:0]               outer_addr_o,
  output logic [ADDR_W-1:0]               inner_addr_o
);
  localparam int OUTER_W = ADDR_W - OFF_W - INNER_W;

  logic [ADDR_W-1:0] outer_ofs, inner_ofs;

  assign len_ok_o     = {1'b0, req_outer_i} < ptlr_i;
  assign outer_ofs    = {{(ADDR_W-OUTER_W-WB){1'b0}}, outer_q_i, {WB{1'b0}}};
  assign inner_ofs    = {{(ADDR_W-INNER_W-WB){1'b0}}, inner_q_i, {WB{1'b0}}};
  assign outer_addr_o = ptbr_q_i + outer_ofs;
  assign inner_addr_o = {obase_q_i, {OFF_W{1'b0}}} + inner_ofs;
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        len_ok_i,
  input  logic        rvalid_i,
  input  logic        pte_ok_i,
  output walk_state_e state_o,
  output fault_e      code_o,
  output logic        accept_o,
  output logic        take_outer_o,
  output logic        take_inner_o
);
  walk_state_e state_q, state_d;
  fault_e      code_q, code_d;
  logic        outer_ph, inner_ph;

  assign outer_ph     = (state_q == ST_RD_OUTER) || (state_q == ST_WT_OUTER);
  assign inner_ph     = (state_q == ST_RD_INNER) || (state_q == ST_WT_INNER);
  assign accept_o     = (state_q == ST_IDLE) && req_valid_i;
  assign take_outer_o = outer_ph && rvalid_i && pte_ok_i;
  assign take_inner_o = inner_ph && rvalid_i && pte_ok_i;

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        state_d = len_ok_i ? ST_RD_OUTER : ST_FAULT;
        code_d  = len_ok_i ? FLT_NONE : FLT_LEN;
      end
      ST_RD_OUTER, ST_WT_OUTER: begin
        if (!rvalid_i)     state_d = ST_WT_OUTER;
        else if (pte_ok_i) state_d = ST_RD_INNER;
        else begin
          state_d = ST_FAULT;
          code_d  = FLT_OUTER;
        end
      end
      ST_RD_INNER, ST_WT_INNER: begin
        if (!rvalid_i)     state_d = ST_WT_INNER;
        else if (pte_ok_i) state_d = ST_DONE;
        else begin
          state_d = ST_FAULT;
          code_d  = FLT_INNER;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      code_q  <= FLT_NONE;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
    end
  end

  assign state_o = state_q;
  assign code_o  = code_q;
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 10,
  parameter int INNER_W = 10,
  parameter int PTE_W   = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            req_valid_i,
  output logic                            req_ready_o,
  input  logic [ADDR_W-1:0]               req_vaddr_i,
  input  logic [ADDR_W-1:0]               ptbr_i,
  input  logic [ADDR_W-OFF_W-INNER_W:0]   ptlr_i,
  output logic                            mem_req_o,
  output logic [ADDR_W-1:0]               mem_addr_o,
  input  logic                            mem_rvalid_i,
  input  logic [PTE_W-1:0]                mem_rdata_i,
  output logic                            rsp_valid_o,
  output logic                            rsp_fault_o,
  output logic [1:0]                      rsp_code_o,
  output logic [ADDR_W-1:0]               rsp_paddr_o
);
  localparam int OUTER_W = ADDR_W - OFF_W - INNER_W;
  localparam int BASE_W  = ADDR_W - OFF_W;
  localparam int WB      = $clog2(PTE_W / 8);

  walk_state_e       state;
  fault_e            code;
  logic              accept, take_outer, take_inner, len_ok;
  logic [ADDR_W-1:0] vaddr_q, ptbr_q, outer_addr, inner_addr;
  logic [BASE_W-1:0] obase_q, pbase_q;
  logic              unused_rsvd;

  assign unused_rsvd = ^mem_rdata_i[OFF_W-1:1];

  ptw_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .len_ok_i     (len_ok),
    .rvalid_i     (mem_rvalid_i),
    .pte_ok_i     (mem_rdata_i[0]),
    .state_o      (state),
    .code_o       (code),
    .accept_o     (accept),
    .take_outer_o (take_outer),
    .take_inner_o (take_inner)
  );

  ptw_addr_gen #(
    .ADDR_W  (ADDR_W),
    .OFF_W   (OFF_W),
    .INNER_W (INNER_W),
    .WB      (WB)
  ) u_agen (
    .req_outer_i  (req_vaddr_i[ADDR_W-1 -: OUTER_W]),
    .ptlr_i       (ptlr_i),
    .ptbr_q_i     (ptbr_q),
    .outer_q_i    (vaddr_q[ADDR_W-1 -: OUTER_W]),
    .inner_q_i    (vaddr_q[OFF_W +: INNER_W]),
    .obase_q_i    (obase_q),
    .len_ok_o     (len_ok),
    .outer_addr_o (outer_addr),
    .inner_addr_o (inner_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vaddr_q <= '0;
      ptbr_q  <= '0;
      obase_q <= '0;
      pbase_q <= '0;
    end else begin
      if (accept) begin
        vaddr_q <= req_vaddr_i;
        ptbr_q  <= ptbr_i;
      end
      if (take_outer) obase_q <= mem_rdata_i[PTE_W-1 -: BASE_W];
      if (take_inner) pbase_q <= mem_rdata_i[PTE_W-1 -: BASE_W];
    end
  end

  logic outer_ph, inner_ph;
  assign outer_ph = (state == ST_RD_OUTER) || (state == ST_WT_OUTER);
  assign inner_ph = (state == ST_RD_INNER) || (state == ST_WT_INNER);

  assign req_ready_o = (state == ST_IDLE);
  assign mem_req_o   = outer_ph || inner_ph;
  assign mem_addr_o  = outer_ph ? outer_addr : inner_addr;
  assign rsp_valid_o = (state == ST_DONE) || (state == ST_FAULT);
  assign rsp_fault_o = (state == ST_FAULT);
  assign rsp_code_o  = (state == ST_FAULT) ? code : FLT_NONE;
  assign rsp_paddr_o = (state == ST_DONE) ? {pbase_q, vaddr_q[OFF_W-1:0]} : '0;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rvalid_i,
  input logic              rsp_valid_o,
  input logic              rsp_fault_o,
  input logic [1:0]        rsp_code_o,
  input logic [ADDR_W-1:0] rsp_paddr_o
);
  // R8
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));

  // R9
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  // R10
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o);

  // R10
  fault_paddr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> rsp_paddr_o == '0 && rsp_code_o != 2'd0);

  // R2
  ok_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_fault_o |-> rsp_code_o == 2'd0);

  // R5
  len_nomem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_code_o == 2'd1 |-> $past(req_ready_o) && !$past(mem_req_o));

  // R6
  outer_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_code_o == 2'd2 |-> $past(mem_req_o && mem_rvalid_i));
endmodule

bind ptw_walker ptw_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_fault_o  (rsp_fault_o),
  .rsp_code_o   (rsp_code_o),
  .rsp_paddr_o  (rsp_paddr_o)
);

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] ptbr = '0;
  logic [12:0] ptlr = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid, rsp_fault;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_paddr;

  always #2.5 clk = ~clk;

  ptw_walker u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .ptbr_i(ptbr), .ptlr_i(ptlr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault),
    .rsp_code_o(rsp_code), .rsp_paddr_o(rsp_paddr)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pte(input logic [31:0] a, input bit absent);
    logic [31:0] m;
    m = (a ^ (a << 7) ^ 32'h5A5A_1C00) * 32'd2654435761;
    return {m[31:10], 9'd0, ~absent};
  endfunction

  // memory model
  int          lat_cfg = 0;
  bit          inv_o = 0, inv_i = 0;
  int          base_n = 0, reads_n = 0, cnt = 0, stab_err = 0;
  logic [31:0] held = '0, log_prev = '0, log_last = '0;

  always @(negedge clk) begin
    if (mem_rvalid) begin
      mem_rvalid = 1'b0;
      cnt = 0;
    end else if (mem_req) begin
      if (cnt == 0) held = mem_addr;
      else if (mem_addr !== held) stab_err++;
      if (cnt >= lat_cfg) begin
        mem_rdata  = pte(mem_addr, (reads_n == base_n) ? inv_o : inv_i);
        mem_rvalid = 1'b1;
        log_prev   = log_last;
        log_last   = mem_addr;
        reads_n++;
      end else cnt++;
    end
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] pb, input logic [12:0] pl,
                      input int lat, input bit io, input bit ii);
    logic [11:0] oi;
    logic [9:0]  ii_x;
    logic [31:0] oaddr, oe, iaddr, ie, pa;
    int          exp_code, exp_reads, s0;
    bit          got;
    oi = va[31:20];
    ii_x = va[19:10];
    oaddr = pb + {18'd0, oi, 2'b00};
    oe = pte(oaddr, 1'b0);
    iaddr = {oe[31:10], 10'd0} + {20'd0, ii_x, 2'b00};
    ie = pte(iaddr, 1'b0);
    pa = {ie[31:10], va[9:0]};
    if ({1'b0, oi} >= pl) exp_code = 1;
    else if (io)          exp_code = 2;
    else if (ii)          exp_code = 3;
    else                  exp_code = 0;
    exp_reads = (exp_code == 1) ? 0 : (exp_code == 2) ? 1 : 2;

    lat_cfg = lat; inv_o = io; inv_i = ii;
    base_n = reads_n; s0 = stab_err;
    chk(req_ready === 1'b1, "R9", "ready before request", {31'd0, req_ready}, 32'd1);
    req_vaddr = va; ptbr = pb; ptlr = pl; req_valid = 1'b1;
    got = 0;
    for (int n = 0; n < 100; n++) begin
      @(negedge clk);
      if (rsp_valid === 1'b1) begin got = 1; break; end
      chk(req_ready === 1'b0, "R9", "ready while busy", {31'd0, req_ready}, 32'd0);
      // scramble inputs while busy
      req_vaddr = ~va ^ n; ptbr = pb ^ 32'hFFFF_F000; ptlr = 13'd4096 - pl;
    end
    req_valid = 1'b0;
    chk(got, "R9", "response arrived", {31'd0, got}, 32'd1);
    if (exp_code == 1) begin
      chk(rsp_fault === 1'b1 && rsp_code === 2'd1, "R5", "length fault code", {30'd0, rsp_code}, 32'd1);
    end else if (exp_code == 2) begin
      chk(rsp_fault === 1'b1 && rsp_code === 2'd2, "R6", "outer fault code", {30'd0, rsp_code}, 32'd2);
      chk(log_last === oaddr, "R3", "outer address", log_last, oaddr);
    end else if (exp_code == 3) begin
      chk(rsp_fault === 1'b1 && rsp_code === 2'd3, "R7", "inner fault code", {30'd0, rsp_code}, 32'd3);
      chk(log_prev === oaddr, "R3", "outer address", log_prev, oaddr);
      chk(log_last === iaddr, "R4", "inner address", log_last, iaddr);
    end else begin
      chk(rsp_fault === 1'b0 && rsp_code === 2'd0, "R2", "success code", {30'd0, rsp_code}, 32'd0);
      chk(rsp_paddr === pa, "R2", "physical address", rsp_paddr, pa);
      chk(log_prev === oaddr, "R11", "first read is outer", log_prev, oaddr);
      chk(log_last === iaddr, "R4", "inner address", log_last, iaddr);
    end
    if (exp_code != 0)
      chk(rsp_paddr === 32'd0, "R10", "paddr zero on fault", rsp_paddr, 32'd0);
    chk(reads_n - base_n == exp_reads, "R11", "read count", reads_n - base_n, exp_reads);
    chk(stab_err == s0, "R8", "request held stable", stab_err - s0, 32'd0);
    @(negedge clk);
    chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R10", "one-cycle pulse",
        {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && mem_req === 1'b0 && rsp_valid === 1'b0, "R1", "reset state",
        {29'd0, req_ready, mem_req, rsp_valid}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && mem_req === 1'b0, "R1", "idle after reset",
        {30'd0, req_ready, mem_req}, 32'd2);

    for (int lat = 0; lat < 4; lat++) begin
      for (int o = 0; o < 21; o++) begin
        for (int m = 0; m < 3; m++) begin
          logic [31:0] va;
          va = {o[11:0], 10'((o * 37) % 1024), 10'((o * 53 + lat) % 1024)};
          walk(va, (lat[0] ? 32'h8000_0400 : 32'h0001_0000), 13'd16, lat, m == 1, m == 2);
        end
      end
      // boundary fields and length extremes
      walk(32'hFFF0_03FF, 32'h0002_0000, 13'd4096, lat, 0, 0);
      walk(32'hFFFF_FC00, 32'h0002_0000, 13'd4095, lat, 0, 0);
      walk(32'h000F_FFFF, 32'hFFFF_FFF0, 13'd1, lat, 0, 0);
      walk(32'h0000_0000, 32'h0003_0000, 13'd0, lat, 0, 0);
      walk(32'hABCD_E123, 32'h0004_0000, 13'd4096, lat, 0, 1);
      walk(32'hABCD_E123, 32'h0004_0000, 13'd4096, lat, 1, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule